// File: doc/BRIEF.md
# Wired Interrupt to Message Converter

This block watches a bank of wired interrupt lines and turns each one that fires into a single posted write on a message master port. Every write goes to a fixed doorbell address. Its data word carries a per-line event identifier and a device identifier, both taken from that line's vector register. A downstream translation unit then delivers the write as a message-signalled interrupt.

Software configures the block through a small register slave. Each line has a trigger-type bit that selects level-high or rising-edge, and a vector register. When a line fires, its status bit is set. Software ends the interrupt by writing one to that status bit in a write-one-to-clear array. Until then the line stays silent. When several lines are waiting at once, the lowest-numbered line is sent first.

Lines are grouped into nodes of `PPN` lines. Node *n* (counting from 1) has a 0x1000-byte window at address *n*·0x1000. The first `RSV` global line numbers are reserved, so local line *k* of node *n* has global number `RSV + (n-1)·PPN + k`.

Top module: `irq_msg_bridge`

## Requirements
- R1: After reset, `msg_valid` is 0. Every type register, vector register and status word reads as 0.
- R2: A register read issued with `reg_rd` returns its data on `reg_rdata` with `reg_rvalid` high one cycle later.
  - Type bits: the bit for local line k is bit k%32 of the word at node base + (k/32)·4.
  - Vector register: line k's register is at node base + 0x200 + k·4. Bits [21:12] are the event id and bits [11:0] are the device id. Reads return the last written value, with bits [31:22] reading 0.
- R3: With type bit 0 (rising-edge), a 0→1 change on a line sets its status. On the third rising clock edge after the line is first sampled high, `msg_valid` goes high with `msg_addr` equal to `DOORBELL` and `msg_data` = {10'b0, event id, device id}.
- R4: With type bit 1 (level-high), a line that is high sets its status. A message follows with the same timing and data format as R3.
- R5: While a line's status bit is set, the line sends no further message, whether its input stays high or a new rising edge arrives.
- R6: The status array starts at 0xA000 and is indexed by global line number g: word 0xA000 + (g/32)·4, bit g%32. Writing 1 to a bit clears that status on the next edge. Writing 0 leaves it unchanged. Reads return the current status bits.
- R7: A level-high line that is still high when its status is cleared sets its status again one cycle later. It then sends a new message.
- R8: A rising-edge line whose input is still high when its status is cleared stays clear and sends nothing until the next rising edge.
- R9: When several lines are waiting, the line with the lowest index is sent first and the others follow in order.
- R10: Once `msg_valid` is high, it and `msg_data` stay unchanged until a cycle with `msg_ready` high. After that cycle `msg_valid` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NODES*PPN | Wired interrupt lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | MSG_AW | Doorbell address |
| msg_data | output | 32 | Message payload: event id and device id |

## Verification
When the issuer is idle, a line is first sampled high on one edge. Its status is set on that same edge and the message becomes valid two edges later, on the third edge. The bench drives each stimulus at a falling edge, counts rising edges with one-cycle steps, and samples at the falling edge that follows the edge where the result is due. It also checks that the output is still low one edge earlier.

A status clear takes effect on the edge that accepts the write. A re-armed level line therefore shows a new message four edges after that write. After a handshake, the next waiting line appears two edges later. Read data is checked one edge after the read strobe.

// File: rtl/imb_pkg.sv
package imb_pkg;
  localparam int VEC_W = 22;

  typedef enum logic [1:0] {
    IS_IDLE,
    IS_FETCH,
    IS_SEND
  } issue_state_e;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_MISC,
    RK_VEC
  } rd_kind_e;
endpackage

// File: rtl/imb_vec_ram.sv
module imb_vec_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int W     = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] a_addr,
  output logic [W-1:0]  a_data,
  input  logic [AW-1:0] b_addr,
  output logic [W-1:0]  b_data
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] seen;
  logic [W-1:0]     a_raw, b_raw;
  logic             a_ok, b_ok;

  // storage without reset so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_raw <= mem[a_addr];
    b_raw <= mem[b_addr];
  end

  // written-flags give reset-to-zero read behaviour
  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      a_ok <= 1'b0;
      b_ok <= 1'b0;
    end else begin
      if (we) seen[waddr] <= 1'b1;
      a_ok <= seen[a_addr];
      b_ok <= seen[b_addr];
    end
  end

  assign a_data = a_ok ? a_raw : '0;
  assign b_data = b_ok ? b_raw : '0;
endmodule

// File: rtl/imb_regfile.sv
module imb_regfile
  import imb_pkg::*;
#(
  parameter int NODES  = 1,
  parameter int PPN    = 128,
  parameter int RSV    = 64,
  parameter int PINS   = NODES * PPN,
  parameter int PIDX_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic [PINS-1:0]   status_i,
  output logic [PINS-1:0]   type_o,
  output logic [PINS-1:0]   clr_o,
  output logic              vec_we,
  output logic [PIDX_W-1:0] vec_idx,
  output logic [VEC_W-1:0]  vec_wdata,
  input  logic [VEC_W-1:0]  vec_rdata
);
  localparam int TWORDS    = PINS / 32;
  localparam int CLR_WORDS = (RSV + PINS) / 32;
  localparam int VEC_BASE  = 'h200;
  localparam int CLR_BASE  = 'hA000;

  logic [PINS-1:0] type_q;
  logic            in_node, is_type, is_vec, is_clr;
  int              nidx, tword, vidx, cword;
  logic [31:0]     tword_data, sword_data;
  logic [RSV+PINS-1:0] stat_ext;
  logic [31:0]     misc_q;
  rd_kind_e        rk_q;

  always_comb begin
    in_node = (reg_addr[15:12] != 4'd0) && (int'(reg_addr[15:12]) <= NODES);
    nidx    = in_node ? int'(reg_addr[15:12]) - 1 : 0;
    is_type = in_node && (int'(reg_addr[11:0]) < PPN / 8);
    tword   = nidx * (PPN / 32) + int'(reg_addr[11:2]);
    is_vec  = in_node && (int'(reg_addr[11:0]) >= VEC_BASE)
              && (int'(reg_addr[11:0]) < VEC_BASE + PPN * 4);
    vidx    = nidx * PPN + (int'(reg_addr[11:0]) - VEC_BASE) / 4;
    is_clr  = (int'(reg_addr) >= CLR_BASE) && ((int'(reg_addr) - CLR_BASE) / 4 < CLR_WORDS);
    cword   = (int'(reg_addr) - CLR_BASE) / 4;
  end

  // write-one-to-clear pulses, indexed by global line number
  always_comb begin
    for (int i = 0; i < PINS; i++)
      clr_o[i] = reg_wr && is_clr && (cword == (RSV + i) / 32) && reg_wdata[(RSV + i) % 32];
  end

  assign vec_we    = reg_wr && is_vec;
  assign vec_idx   = is_vec ? PIDX_W'(vidx) : '0;
  assign vec_wdata = reg_wdata[VEC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= '0;
    end else if (reg_wr && is_type) begin
      for (int w = 0; w < TWORDS; w++)
        if (tword == w) type_q[w*32 +: 32] <= reg_wdata;
    end
  end
  assign type_o = type_q;

  assign stat_ext = {status_i, {RSV{1'b0}}};

  always_comb begin
    tword_data = '0;
    sword_data = '0;
    for (int w = 0; w < TWORDS; w++)
      if (tword == w) tword_data = type_q[w*32 +: 32];
    for (int w = 0; w < CLR_WORDS; w++)
      if (cword == w) sword_data = stat_ext[w*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      rk_q       <= RK_NONE;
      misc_q     <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        if (is_vec) begin
          rk_q   <= RK_VEC;
          misc_q <= '0;
        end else if (is_type) begin
          rk_q   <= RK_MISC;
          misc_q <= tword_data;
        end else if (is_clr) begin
          rk_q   <= RK_MISC;
          misc_q <= sword_data;
        end else begin
          rk_q   <= RK_NONE;
          misc_q <= '0;
        end
      end
    end
  end

  assign reg_rdata = (rk_q == RK_VEC) ? {{(32-VEC_W){1'b0}}, vec_rdata} : misc_q;
endmodule

// File: rtl/imb_pin_track.sv
module imb_pin_track #(
  parameter int PINS   = 128,
  parameter int PIDX_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   irq_in,
  input  logic [PINS-1:0]   type_i,
  input  logic [PINS-1:0]   clr_i,
  input  logic              take_valid,
  input  logic [PIDX_W-1:0] take_idx,
  output logic [PINS-1:0]   status_o,
  output logic [PINS-1:0]   queued_o
);
  logic [PINS-1:0] prev_q, trig, set_v, take_mask;

  // type 1 = level-high, type 0 = rising-edge
  assign trig      = (type_i & irq_in) | (~type_i & irq_in & ~prev_q);
  assign set_v     = trig & ~status_o;
  assign take_mask = take_valid ? (PINS'(1) << take_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      status_o <= '0;
      queued_o <= '0;
    end else begin
      prev_q   <= irq_in;
      status_o <= (status_o & ~clr_i) | set_v;
      queued_o <= (queued_o & ~take_mask) | set_v;
    end
  end
endmodule

// File: rtl/imb_issue.sv
module imb_issue
  import imb_pkg::*;
#(
  parameter int PINS   = 128,
  parameter int PIDX_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   queued_i,
  output logic              take_valid,
  output logic [PIDX_W-1:0] take_idx,
  input  logic [VEC_W-1:0]  vec_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [31:0]       msg_data
);
  issue_state_e state_q;
  logic         found;

  // lowest index wins
  always_comb begin
    found    = 1'b0;
    take_idx = '0;
    for (int i = PINS - 1; i >= 0; i--) begin
      if (queued_i[i]) begin
        found    = 1'b1;
        take_idx = PIDX_W'(i);
      end
    end
  end

  assign take_valid = (state_q == IS_IDLE) && found;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= IS_IDLE;
      msg_valid <= 1'b0;
      msg_data  <= '0;
    end else begin
      case (state_q)
        IS_IDLE:  if (found) state_q <= IS_FETCH;
        IS_FETCH: begin
          msg_data  <= {{(32-VEC_W){1'b0}}, vec_rdata};
          msg_valid <= 1'b1;
          state_q   <= IS_SEND;
        end
        IS_SEND: if (msg_ready) begin
          msg_valid <= 1'b0;
          state_q   <= IS_IDLE;
        end
        default: state_q <= IS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
  import imb_pkg::*;
#(
  parameter int               NODES    = 1,
  parameter int               PPN      = 128,
  parameter int               RSV      = 64,
  parameter int               MSG_AW   = 32,
  parameter logic [MSG_AW-1:0] DOORBELL = 32'hFEE0_0040
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NODES*PPN-1:0]  irq_in,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [15:0]           reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  reg_rvalid,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [MSG_AW-1:0]     msg_addr,
  output logic [31:0]           msg_data
);
  localparam int PINS   = NODES * PPN;
  localparam int PIDX_W = (PINS > 1) ? $clog2(PINS) : 1;

  logic [PINS-1:0]   status_w, queued_w, type_w, clr_w;
  logic              take_v;
  logic [PIDX_W-1:0] take_idx_w, vec_idx_w;
  logic              vec_we_w;
  logic [VEC_W-1:0]  vec_wdata_w, vec_reg_rd_w, vec_msg_rd_w;

  imb_regfile #(.NODES(NODES), .PPN(PPN), .RSV(RSV), .PINS(PINS), .PIDX_W(PIDX_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .status_i(status_w), .type_o(type_w), .clr_o(clr_w),
    .vec_we(vec_we_w), .vec_idx(vec_idx_w), .vec_wdata(vec_wdata_w), .vec_rdata(vec_reg_rd_w)
  );

  imb_vec_ram #(.DEPTH(PINS), .AW(PIDX_W), .W(VEC_W)) u_vram (
    .clk(clk), .rst(rst), .we(vec_we_w), .waddr(vec_idx_w), .wdata(vec_wdata_w),
    .a_addr(vec_idx_w), .a_data(vec_reg_rd_w),
    .b_addr(take_idx_w), .b_data(vec_msg_rd_w)
  );

  imb_pin_track #(.PINS(PINS), .PIDX_W(PIDX_W)) u_track (
    .clk(clk), .rst(rst), .irq_in(irq_in), .type_i(type_w), .clr_i(clr_w),
    .take_valid(take_v), .take_idx(take_idx_w), .status_o(status_w), .queued_o(queued_w)
  );

  imb_issue #(.PINS(PINS), .PIDX_W(PIDX_W)) u_issue (
    .clk(clk), .rst(rst), .queued_i(queued_w), .take_valid(take_v), .take_idx(take_idx_w),
    .vec_rdata(vec_msg_rd_w), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data)
  );

  assign msg_addr = DOORBELL;
endmodule

// File: rtl/imb_checker.sv
module imb_checker #(
  parameter int PINS   = 128,
  parameter int PIDX_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [PINS-1:0]   status,
  input logic [PINS-1:0]   clr,
  input logic [PINS-1:0]   queued,
  input logic              take_valid,
  input logic [PIDX_W-1:0] take_idx,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [31:0]       msg_data,
  input logic              reg_rd,
  input logic              reg_rvalid
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R2
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|status) |=> ((($past(status) & ~$past(clr)) & ~status) == '0)); // R5
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|(clr & status)) |=> ((($past(clr) & $past(status)) & status) == '0)); // R6
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> (queued[take_idx] && ((queued & ~({PINS{1'b1}} << take_idx)) == '0))); // R9
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data))); // R10
endmodule

bind irq_msg_bridge imb_checker #(.PINS(PINS), .PIDX_W(PIDX_W)) u_chk (
  .clk(clk), .rst(rst), .status(status_w), .clr(clr_w), .queued(queued_w),
  .take_valid(take_v), .take_idx(take_idx_w), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_data(msg_data), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid)
);

// File: tb/irq_msg_bridge_test.sv
module irq_msg_bridge_test;
  localparam logic [31:0] DB = 32'hFEE0_0040;

  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] irq_in;
  logic         reg_wr, reg_rd;
  logic [15:0]  reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         reg_rvalid;
  logic         msg_valid, msg_ready;
  logic [31:0]  msg_addr, msg_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_msg_bridge uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    chk("R2 rvalid", {31'b0, reg_rvalid}, 32'd1);
    chk(req, reg_rdata, exp);
  endtask

  // R1: reset state
  task automatic t_reset();
    chk("R1 valid", {31'b0, msg_valid}, 32'd0);
    rd_chk("R1 type", 16'h1000, 32'h0);
    rd_chk("R1 vector", 16'h1200, 32'h0);
    rd_chk("R1 status", 16'hA008, 32'h0);
  endtask

  // R2: register readback
  task automatic t_regs();
    wr(16'h1004, 32'hA5A5_0001);
    rd_chk("R2 type", 16'h1004, 32'hA5A5_0001);
    wr(16'h1204, 32'hFFFF_FFFF);
    rd_chk("R2 vector", 16'h1204, 32'h003F_FFFF);
  endtask

  // R3, R5, R6, R8, R10: edge line 5 (global 69, status word 0xA008 bit 5)
  task automatic t_edge();
    msg_ready = 1'b0;
    wr(16'h1214, 32'h0015_5ABC);
    irq_in[5] = 1'b1;
    tick(); chk("R3 early1", {31'b0, msg_valid}, 32'd0);
    tick(); chk("R3 early2", {31'b0, msg_valid}, 32'd0);
    tick(); chk("R3 valid", {31'b0, msg_valid}, 32'd1);
    chk("R3 data", msg_data, 32'h0015_5ABC);
    chk("R3 addr", msg_addr, DB);
    repeat (3) tick();
    chk("R10 held", {31'b0, msg_valid}, 32'd1);
    chk("R10 stable", msg_data, 32'h0015_5ABC);
    msg_ready = 1'b1; tick(); msg_ready = 1'b0;
    chk("R10 drop", {31'b0, msg_valid}, 32'd0);
    rd_chk("R6 status set", 16'hA008, 32'h0000_0020);
    irq_in[5] = 1'b0; tick(); irq_in[5] = 1'b1;
    repeat (6) tick();
    chk("R5 edge while set", {31'b0, msg_valid}, 32'd0);
    wr(16'hA008, 32'h0);
    rd_chk("R6 zero write", 16'hA008, 32'h0000_0020);
    wr(16'hA008, 32'h0000_0020);
    rd_chk("R6 cleared", 16'hA008, 32'h0);
    repeat (5) tick();
    chk("R8 no message", {31'b0, msg_valid}, 32'd0);
    rd_chk("R8 status", 16'hA008, 32'h0);
    irq_in[5] = 1'b0;
  endtask

  // R4, R5, R7: level line 40 (global 104, status word 0xA00C bit 8)
  task automatic t_level();
    msg_ready = 1'b1;
    wr(16'h1004, 32'h0000_0100);
    wr(16'h12A0, 32'h003F_F001);
    irq_in[40] = 1'b1;
    tick(); tick(); chk("R4 early", {31'b0, msg_valid}, 32'd0);
    tick(); chk("R4 valid", {31'b0, msg_valid}, 32'd1);
    chk("R4 data", msg_data, 32'h003F_F001);
    tick(); chk("R4 accepted", {31'b0, msg_valid}, 32'd0);
    repeat (6) tick();
    chk("R5 level held", {31'b0, msg_valid}, 32'd0);
    rd_chk("R6 level status", 16'hA00C, 32'h0000_0100);
    wr(16'hA00C, 32'h0000_0100);
    tick(); tick();
    chk("R7 early", {31'b0, msg_valid}, 32'd0);
    tick(); chk("R7 rearm", {31'b0, msg_valid}, 32'd1);
    chk("R7 data", msg_data, 32'h003F_F001);
    tick();
    irq_in[40] = 1'b0;
    tick();
    wr(16'hA00C, 32'h0000_0100);
    rd_chk("R6 level cleared", 16'hA00C, 32'h0);
  endtask

  // R9: lines 3 and 9 together
  task automatic t_prio();
    msg_ready = 1'b0;
    wr(16'h120C, 32'h0000_0003);
    wr(16'h1224, 32'h0000_0009);
    irq_in[3] = 1'b1; irq_in[9] = 1'b1;
    repeat (3) tick();
    chk("R9 first valid", {31'b0, msg_valid}, 32'd1);
    chk("R9 first data", msg_data, 32'h0000_0003);
    msg_ready = 1'b1; tick(); msg_ready = 1'b0;
    chk("R9 gap", {31'b0, msg_valid}, 32'd0);
    tick(); tick();
    chk("R9 second valid", {31'b0, msg_valid}, 32'd1);
    chk("R9 second data", msg_data, 32'h0000_0009);
    msg_ready = 1'b1; tick(); msg_ready = 1'b0;
    irq_in[3] = 1'b0; irq_in[9] = 1'b0;
    wr(16'hA008, 32'h0000_0208);
    rd_chk("R6 both cleared", 16'hA008, 32'h0);
    chk("R9 idle", {31'b0, msg_valid}, 32'd0);
  endtask

  initial begin
    rst = 1'b1; irq_in = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0; msg_ready = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_regs();
    t_edge();
    t_level();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule